// File: doc/BRIEF.md
# Dual-Modulus Clock Prescaler

This block divides an incoming clock by one of four moduli: 128 or 129 in the wide family, 64 or 65 in the narrow family. A front divider normally counts four input clocks per step. Behind it sits a chain of five synchronous binary stages that advances once per front-divider step. A family select removes the fourth binary stage from the carry path, which halves the number of steps in one output period. A per-period modulus control adds one input clock to the period. It does this by letting the front divider count five instead of four, and only during the last step of the chain.

A frequency synthesizer uses the block as the dual-modulus element of a pulse-swallow loop. The family select is a static strap with a default of low. The modulus control is updated once per output period, and it is sampled at one defined clock edge. The output is a registered square-ish wave. It is low from count 1 up to count half-1. It rises at the half count (64 or 32) and stays high until the period's final count, where it drops. That falling edge marks the period boundary.

Counts are numbered 1..P inside each period, where P is the active modulus. Count 1 is the state entered by reset or by the edge after the final count.

Top module: `dual_mod_divider`

## Requirements
- R1: With `mod_sel`=1 and `fam_sel`=0, the output falls every 128 input clock edges. Each chain step lasts exactly four input clocks.
- R2: With `mod_sel`=0 and `fam_sel`=0, the output falls every 129 edges. The fifth front-divider clock occurs only in the last chain step.
- R3: With `mod_sel`=1 and `fam_sel`=1, the output falls every 64 edges. The fourth binary stage (bit index 3) is held clear and skipped by the carry.
- R4: With `mod_sel`=0 and `fam_sel`=1, the output falls every 65 edges.
- R5: `mod_sel` is sampled only at the rising edge that enters count B-3, where B is 128 or 64 for the active family. `mod_sel`=0 at that edge stretches the current period by one clock. The value of `mod_sel` at every other edge has no effect on the period.
- R6: The output is low during the final count of each period, and the transition into the final count is the only falling edge of the output outside reset.
- R7: The output rises on entry to count 64 in the wide family and count 32 in the narrow family, in both stretched and unstretched periods.
- R8: A synchronous active-high `rst` puts the block in count 1 with the output low, the front divider, the chain and the stretch decision all cleared. After release, the first fall comes on entering the period's final count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | 1 selects the base modulus, 0 adds one clock to the period |
| fam_sel | input | 1 | 0 selects 128/129, 1 selects 64/65; static strap |
| div_out | output | 1 | Divided clock: rises at the half count, falls at the final count |

## Verification
The bench keeps its own count of the period position and compares the output on every cycle. It measures the spacing between consecutive falling edges under constant, alternating and per-cycle random modulus control in both families. With random control, a design that sampled `mod_sel` one edge early or late, or kept sampling it through the last step, produces periods that disagree with the bench's value taken at count B-3. A design whose extra clock landed in a middle step rather than the last one would move the rising edge off 64 or 32. A bypass that reloaded a count instead of skipping the stage would show up as a narrow-family period of the wrong length after a reset-with-strap-change. A reset asserted mid-period catches a design that leaves the stretch decision or a chain bit set.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  // Logical step index of the chain: the bits of the active stages
  // packed together, skipping the bypassed stage when it is removed.
  function automatic int unsigned squeeze(input logic [31:0] bits,
                                          input int unsigned n_stages,
                                          input int unsigned skip_idx,
                                          input logic        drop);
    int unsigned r;
    int unsigned o;
    r = 0;
    o = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n_stages && !(drop && i == skip_idx)) begin
        r = r | (32'(bits[i]) << o);
        o = o + 1;
      end
    end
    return r;
  endfunction

  // Count number (1-based) inside a period for a given step and phase.
  function automatic int unsigned pos_of(input int unsigned step_idx,
                                         input int unsigned phase,
                                         input int unsigned pre_base);
    return step_idx * pre_base + phase + 1;
  endfunction

  // Base modulus of the active family.
  function automatic int unsigned span_of(input int unsigned pre_base,
                                          input int unsigned n_stages,
                                          input logic        drop);
    return pre_base << (drop ? n_stages - 1 : n_stages);
  endfunction

  // Count on which the output goes high.
  function automatic int unsigned rise_of(input int unsigned pre_base,
                                          input int unsigned n_stages,
                                          input logic        drop);
    return span_of(pre_base, n_stages, drop) / 2;
  endfunction

endpackage

// File: rtl/dmp_prescaler.sv
module dmp_prescaler #(
  parameter int unsigned PRE_BASE = 4,
  localparam int unsigned PW = $clog2(PRE_BASE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          last_grp_i,
  input  logic          stretch_i,
  output logic [PW-1:0] pre_q,
  output logic [PW-1:0] pre_n,
  output logic          tick
);

  localparam logic [PW-1:0] LAST_NORM = PW'(PRE_BASE - 1);
  localparam logic [PW-1:0] LAST_LONG = PW'(PRE_BASE);

  logic [PW-1:0] last_val;
  logic          long_step;

  assign long_step = last_grp_i && stretch_i;
  assign last_val  = long_step ? LAST_LONG : LAST_NORM;
  assign tick      = (pre_q == last_val);
  assign pre_n     = tick ? '0 : pre_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_n;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_q <= LAST_LONG); // R2

  AST_FIFTH_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
    (pre_q == LAST_LONG) |-> (last_grp_i && stretch_i)); // R2

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pre_q == '0)); // R1

endmodule

// File: rtl/dmp_stage_chain.sv
module dmp_stage_chain #(
  parameter int unsigned STAGES    = 5,
  parameter int unsigned BYP_STAGE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bypass,
  output logic [STAGES-1:0] q,
  output logic [STAGES-1:0] q_n,
  output logic              at_max,
  output logic              at_max_n,
  output logic              enter_last
);

  logic [STAGES:0]   carry;
  logic [STAGES-1:0] fill_mask;

  assign carry[0] = tick;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == BYP_STAGE) begin : g_skip
      assign q_n[i]       = bypass ? 1'b0 : (q[i] ^ carry[i]);
      assign carry[i+1]   = bypass ? carry[i] : (carry[i] & q[i]);
      assign fill_mask[i] = bypass;
    end else begin : g_bin
      assign q_n[i]       = q[i] ^ carry[i];
      assign carry[i+1]   = carry[i] & q[i];
      assign fill_mask[i] = 1'b0;
    end
  end

  assign at_max     = &(q | fill_mask);
  assign at_max_n   = &(q_n | fill_mask);
  assign enter_last = tick && !at_max && at_max_n;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_n;
  end

  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !bypass) |=> $stable(q)); // R1

  AST_SKIPPED_STAGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bypass && $past(bypass) && !$past(rst)) |-> !q[BYP_STAGE]); // R3

  AST_WRAP_FROM_MAX: assert property (@(posedge clk) disable iff (rst)
    (tick && at_max) |=> (q == '0)); // R6

endmodule

// File: rtl/dmp_mod_latch.sv
module dmp_mod_latch (
  input  logic clk,
  input  logic rst,
  input  logic enter_last,
  input  logic mod_sel,
  output logic stretch_q,
  output logic stretch_n
);

  assign stretch_n = enter_last ? !mod_sel : stretch_q;

  always_ff @(posedge clk) begin
    if (rst) stretch_q <= 1'b0;
    else     stretch_q <= stretch_n;
  end

  AST_MC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    enter_last |=> (stretch_q == !$past(mod_sel))); // R5

  AST_MC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !enter_last |=> $stable(stretch_q)); // R5

endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
  parameter int unsigned PRE_BASE  = 4,
  parameter int unsigned STAGES    = 5,
  parameter int unsigned BYP_STAGE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_sel,
  input  logic fam_sel,
  output logic div_out
);
  import dmp_pkg::*;

  localparam int unsigned PW = $clog2(PRE_BASE + 1);

  logic [PW-1:0]     pre_q;
  logic [PW-1:0]     pre_n;
  logic              tick;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;
  logic              at_max;
  logic              at_max_n;
  logic              enter_last;
  logic              stretch_q;
  logic              stretch_n;

  // Named internal events for the assertions
  int unsigned pos_now;
  int unsigned pos_n;
  int unsigned rise_pos;
  logic        final_now;
  logic        final_n;
  logic        div_n;

  dmp_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .last_grp_i (at_max),
    .stretch_i  (stretch_q),
    .pre_q      (pre_q),
    .pre_n      (pre_n),
    .tick       (tick)
  );

  dmp_stage_chain #(.STAGES(STAGES), .BYP_STAGE(BYP_STAGE)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .bypass     (fam_sel),
    .q          (chain_q),
    .q_n        (chain_n),
    .at_max     (at_max),
    .at_max_n   (at_max_n),
    .enter_last (enter_last)
  );

  dmp_mod_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .enter_last (enter_last),
    .mod_sel    (mod_sel),
    .stretch_q  (stretch_q),
    .stretch_n  (stretch_n)
  );

  assign rise_pos = rise_of(PRE_BASE, STAGES, fam_sel);

  assign pos_now = pos_of(squeeze(32'(chain_q), STAGES, BYP_STAGE, fam_sel),
                          32'(pre_q), PRE_BASE);
  assign pos_n   = pos_of(squeeze(32'(chain_n), STAGES, BYP_STAGE, fam_sel),
                          32'(pre_n), PRE_BASE);

  assign final_now = at_max &&
                     (pre_q == (stretch_q ? PW'(PRE_BASE) : PW'(PRE_BASE - 1)));
  assign final_n   = at_max_n &&
                     (pre_n == (stretch_n ? PW'(PRE_BASE) : PW'(PRE_BASE - 1)));

  assign div_n = (pos_n >= rise_pos) && !final_n;

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= div_n;
  end

  AST_FALL_AT_FINAL: assert property (@(posedge clk) disable iff (rst)
    ($fell(div_out) && !$past(rst)) |-> final_now); // R6

  AST_LOW_IN_FINAL: assert property (@(posedge clk) disable iff (rst)
    final_now |-> !div_out); // R6

  AST_RISE_AT_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> (pos_now == rise_pos)); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!div_out && pre_q == '0 && chain_q == '0 && !stretch_q)); // R8

endmodule

// File: tb/dual_mod_divider_tb.sv
module dual_mod_divider_tb;

  localparam int CLK_NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_sel = 1'b1;
  logic fam_sel = 1'b0;
  logic div_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench reference state
  int k = 1;          // current count in period
  int st = 0;         // stretch decision of this period
  int since_fall = 1; // edges since the last falling edge
  logic prev_out = 1'b0;
  bit rst_edge = 0;
  int policy = 0;     // 0 const 1, 1 const 0, 2 toggle per period, 3 random

  always #(CLK_NS/2) clk = ~clk;

  dual_mod_divider u_dut (
    .clk     (clk),
    .rst     (rst),
    .mod_sel (mod_sel),
    .fam_sel (fam_sel),
    .div_out (div_out)
  );

  function automatic int base_of(input logic fam);
    return fam ? 64 : 128;
  endfunction

  function automatic logic level_of(input int cnt, input int per, input logic fam);
    return (cnt >= base_of(fam) / 2) && (cnt != per);
  endfunction

  function automatic string period_req(input logic fam, input int s);
    if (policy == 3) return "R5";
    if (!fam) return s ? "R2" : "R1";
    return s ? "R4" : "R3";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (count %0d, fam %0b)",
               req, act, exp, k, fam_sel);
    end
  endtask

  task automatic one_cycle();
    int per;
    string req;
    logic fell;
    @(posedge clk);
    rst_edge = rst;
    if (rst) begin
      k = 1; st = 0; since_fall = 1;
    end else begin
      if (k == base_of(fam_sel) + st) k = 1;
      else k = k + 1;
      if (k == base_of(fam_sel) - 3) st = !mod_sel;   // R5 sample edge
      since_fall++;
    end
    @(negedge clk);
    per = base_of(fam_sel) + st;
    if (rst_edge)                      req = "R8";
    else if (k == per)                 req = "R6";
    else if (k == base_of(fam_sel)/2)  req = "R7";
    else                               req = fam_sel ? "R3" : "R1";
    check(req, int'(div_out), int'(level_of(k, per, fam_sel)));
    fell = prev_out && !div_out && !rst_edge;
    if (fell) begin
      check(period_req(fam_sel, st), since_fall, per);
      since_fall = 0;
    end
    prev_out = div_out;
    case (policy)
      0: mod_sel = 1'b1;
      1: mod_sel = 1'b0;
      2: if (fell) mod_sel = ~mod_sel;
      default: mod_sel = 1'($urandom % 2);
    endcase
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) one_cycle();
  endtask

  task automatic apply_reset(input logic fam, input int n);
    rst = 1'b1;
    fam_sel = fam;
    run(n);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R8: output low while reset held
    apply_reset(1'b0, 3);
    check("R8", int'(div_out), 0);
    for (int f = 0; f < 2; f++) begin
      logic fam;
      fam = 1'(f);
      apply_reset(fam, 2);
      policy = 0; mod_sel = 1'b1;
      run(base_of(fam) * 3);
      policy = 1; mod_sel = 1'b0;
      run(base_of(fam) * 3 + 6);
      policy = 2;
      run(base_of(fam) * 4 + 8);
      policy = 3;
      run(base_of(fam) * 8);
      // R8: reset in the middle of a period, then random control again
      run(int'($urandom % 50) + 70);
      apply_reset(fam, 1);
      check("R8", int'(div_out), 0);
      run(base_of(fam) * 3);
    end
    // R5 directed: value away from the sample edge must not matter
    apply_reset(1'b0, 2);
    policy = 3;
    run(128 * 6);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule